// File: doc/BRIEF.md
# Layer-Granular Convergence Monitor for a Layered LDPC Decoder

This block decides when a layered LDPC decoder may stop iterating. After every layer the decoder presents the sign bits of its posterior messages together with a layer strobe and its current iteration index. The monitor keeps one register bit per information bit, holding the hard decisions seen at the previous layer. It XORs each stored bit with the new decision and ORs all the XOR outputs into a single change flag. This small register-plus-compare structure takes the place of a full parity-matrix product, so convergence can be declared at any iteration and not only at an iteration boundary.

A run begins with a start pulse. Stop is raised when a full iteration's worth of consecutive layers shows no hard-decision change, or when the last layer of the final allowed iteration completes. Stop stays high until the next start. One cycle after stop rises, a single-cycle done pulse tells the decoder control to unload the codeword.

The controller has four states, `ST_IDLE`, `ST_RUN`, `ST_FINISH` and `ST_HOLD`, with these transitions:
- **ST_IDLE → ST_RUN**: taken on a start pulse.
- **ST_RUN → ST_FINISH**: taken on a layer strobe that meets the quiet condition or the iteration cap.
- **ST_FINISH → ST_HOLD**: taken unconditionally one cycle later.
- **Any state → ST_RUN**: taken on a start pulse.

Top module: `eth_early_stop`

## Requirements
- R1: After reset, `stop_o` and `done_o` are 0. Layer strobes received before the first start pulse are ignored and raise nothing.
- R2: A hard decision is the sign bit of a posterior message, where 1 means negative. Every accepted strobe replaces the stored decisions with `post_sign_i`. A strobe counts as a change if any bit differs from the stored value, including a single bit at any position.
- R3: `stop_o` rises in the cycle after the strobe that completes LAYERS consecutive accepted strobes, each with no change and each with `iter_idx_i` not equal to 0.
- R4: No strobe carrying `iter_idx_i` = 0 counts as quiet, so no convergence stop can happen during the first iteration.
- R5: A strobe that shows a change restarts the quiet run from zero.
- R6: The block keeps a count of layer position, which is the number of accepted strobes since start modulo LAYERS. A strobe at position LAYERS-1 with `iter_idx_i` ≥ MAX_ITER-1 raises `stop_o` in the next cycle, whether or not any change occurred.
- R7: Once raised, `stop_o` stays at 1 until a start pulse. Strobes received while stopped have no effect.
- R8: `done_o` is 1 for exactly one cycle, in the cycle after `stop_o` rises, and is 0 at all other times.
- R9: A start pulse clears `stop_o`, the stored decisions (to all zeros), the quiet run and the layer position. Start takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle pulse that begins a new codeword |
| layer_done_i | input | 1 | Strobe marking the end of one layer |
| post_sign_i | input | NBITS | Posterior sign bits, valid with the strobe |
| iter_idx_i | input | ITER_W | Current iteration index, counting from 0 |
| stop_o | output | 1 | Stop decision, held until the next start |
| done_o | output | 1 | One-cycle pulse following the stop decision |

## Verification
The assertions assume several things about the inputs:
- The iteration index only advances between strobes.
- MAX_ITER is at least 2, so a strobe in iteration 0 can never also be the capping strobe.
- Start is a single-cycle pulse.

The bench respects these assumptions. It drives the index from nested iteration and layer loops, and it pulses start for exactly one cycle before each codeword. It sweeps the iteration at which the decisions settle across every value from 1 to the cap, flips each bit position on its own, and strobes while stopped and before the first start.

// File: rtl/eth_pkg.sv
package eth_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2,
        ST_HOLD   = 2'd3
    } eth_state_e;
endpackage

// File: rtl/eth_change_detect.sv
module eth_change_detect #(
    parameter int NBITS = 336
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [NBITS-1:0] bits_i,
    output logic             changed_o
);
    logic [NBITS-1:0] hist_q;
    logic [NBITS-1:0] diff;

    // one XOR per stored decision
    for (genvar g = 0; g < NBITS; g++) begin : g_xor
        assign diff[g] = hist_q[g] ^ bits_i[g];
    end

    // wide OR over all XOR outputs
    assign changed_o = |diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hist_q <= '0;
        else if (clear_i) hist_q <= '0;
        else if (load_i)  hist_q <= bits_i;
    end

    // R2: once a vector is loaded, presenting the same vector again reads as no change
    p_reload_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) ##1 $stable(bits_i) |-> !changed_o);
endmodule

// File: rtl/eth_progress.sv
module eth_progress #(
    parameter int LAYERS   = 4,
    parameter int MAX_ITER = 12,
    parameter int ITER_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic              changed_i,
    input  logic [ITER_W-1:0] iter_i,
    output logic              quiet_hit_o,
    output logic              cap_hit_o
);
    localparam int CW = $clog2(LAYERS + 1);
    localparam logic [CW-1:0]     LAST_POS = CW'(LAYERS - 1);
    localparam logic [ITER_W-1:0] LAST_IT  = ITER_W'(MAX_ITER - 1);

    logic [CW-1:0] quiet_q;
    logic [CW-1:0] pos_q;
    logic          quiet_layer;

    assign quiet_layer = !changed_i && (iter_i != '0);
    assign quiet_hit_o = step_i && quiet_layer && (quiet_q == LAST_POS);
    assign cap_hit_o   = step_i && (iter_i >= LAST_IT) && (pos_q == LAST_POS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
            pos_q   <= '0;
        end else if (clear_i) begin
            quiet_q <= '0;
            pos_q   <= '0;
        end else if (step_i) begin
            quiet_q <= quiet_layer ? ((quiet_q == CW'(LAYERS)) ? quiet_q : quiet_q + 1'b1) : '0;
            pos_q   <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    // R3: the quiet run never exceeds one iteration's worth of layers
    p_quiet_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= CW'(LAYERS));
    // R4: a strobe in iteration 0 never completes a quiet run
    p_no_quiet_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && iter_i == '0) |-> !quiet_hit_o);
    // R5: a changed strobe restarts the run
    p_change_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && changed_i && !clear_i) |=> quiet_q == '0);
endmodule

// File: rtl/eth_early_stop.sv
module eth_early_stop
    import eth_pkg::*;
#(
    parameter int NBITS    = 336,
    parameter int LAYERS   = 4,
    parameter int MAX_ITER = 12,
    parameter int ITER_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              layer_done_i,
    input  logic [NBITS-1:0]  post_sign_i,
    input  logic [ITER_W-1:0] iter_idx_i,
    output logic              stop_o,
    output logic              done_o
);
    eth_state_e state_q, state_d;
    logic       step;
    logic       changed;
    logic       quiet_hit;
    logic       cap_hit;
    logic       decide;
    logic       stop_q, done_q;

    assign step   = (state_q == ST_RUN) && layer_done_i && !start_i;
    assign decide = quiet_hit || cap_hit;

    eth_change_detect #(.NBITS(NBITS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .load_i    (step),
        .bits_i    (post_sign_i),
        .changed_o (changed)
    );

    eth_progress #(.LAYERS(LAYERS), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)) u_progress (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .step_i      (step),
        .changed_i   (changed),
        .iter_i      (iter_idx_i),
        .quiet_hit_o (quiet_hit),
        .cap_hit_o   (cap_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RUN;
            ST_RUN:    if (start_i) state_d = ST_RUN;
                       else if (step && decide) state_d = ST_FINISH;
            ST_FINISH: state_d = start_i ? ST_RUN : ST_HOLD;
            ST_HOLD:   if (start_i) state_d = ST_RUN;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINISH) && !start_i;
            if (start_i)            stop_q <= 1'b0;
            else if (step && decide) stop_q <= 1'b1;
        end
    end

    assign stop_o = stop_q;
    assign done_o = done_q;

    // R1: nothing is flagged before the first start
    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!stop_o && !done_o));
    // R7: stop holds until start
    p_stop_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !start_i) |=> stop_o);
    // R8: done follows the rise of stop by one cycle
    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stop_o) && !start_i) |-> ##1 done_o);
    // R8: done is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: start clears the outputs
    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!stop_o && !done_o));
endmodule

// File: tb/eth_early_stop_tb.sv
module eth_early_stop_tb;
    localparam int NB = 8;
    localparam int NL = 4;
    localparam int MI = 12;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          layer_done_i = 1'b0;
    logic [NB-1:0] post_sign_i = '0;
    logic [IW-1:0] iter_idx_i = '0;
    logic          stop_o, done_o;

    always #4 clk = ~clk;

    eth_early_stop #(.NBITS(NB), .LAYERS(NL), .MAX_ITER(MI), .ITER_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .layer_done_i(layer_done_i),
        .post_sign_i(post_sign_i), .iter_idx_i(iter_idx_i), .stop_o(stop_o), .done_o(done_o)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [NB-1:0] m_hist;
    int  m_quiet, m_pos;
    bit  m_run = 0, m_stop = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1; layer_done_i = 1'b0;
        @(negedge clk); start_i = 1'b0;
        m_run = 1; m_stop = 0; m_hist = '0; m_quiet = 0; m_pos = 0;
        chk("R9 stop cleared", int'(stop_o), 0);
    endtask

    task automatic strobe(logic [NB-1:0] bits, int it, string tag);
        bit chg, ql, hit, just;
        just = 0;
        @(negedge clk);
        layer_done_i = 1'b1; post_sign_i = bits; iter_idx_i = IW'(it);
        if (m_run && !m_stop) begin
            chg = (m_hist != bits);
            m_hist = bits;
            ql  = !chg && (it != 0);
            hit = (ql && m_quiet == NL-1) || (it >= MI-1 && m_pos == NL-1);
            m_quiet = ql ? m_quiet + 1 : 0;
            m_pos = (m_pos == NL-1) ? 0 : m_pos + 1;
            if (hit) begin m_stop = 1; just = 1; end
        end
        @(posedge clk); #1;
        chk(tag, int'(stop_o), int'(m_stop));
        @(negedge clk); layer_done_i = 1'b0;
        @(posedge clk); #1;
        chk("R8 done pulse", int'(done_o), int'(just));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset stop", int'(stop_o), 0);
        chk("R1 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        // R1: strobes before any start are ignored, even at the cap
        for (int k = 0; k < NL; k++) strobe(8'h00, MI - 1, "R1 idle strobe");

        // R4 then R3: an all-quiet first iteration, then a quiet second one
        do_start();
        for (int l = 0; l < NL; l++) strobe(8'h00, 0, "R4 no stop in iteration 0");
        for (int l = 0; l < NL; l++) strobe(8'h00, 1, "R3 quiet iteration stops");
        // R7: strobes while stopped are ignored and stop holds
        for (int l = 0; l < NL; l++) strobe(8'hFF, 2, "R7 stop held");

        // R5: a change in the middle of a quiet run restarts it
        do_start();
        for (int l = 0; l < NL; l++) strobe(8'h3C, 0, "R5 warmup");
        for (int l = 0; l < NL - 1; l++) strobe(8'h3C, 1, "R5 partial run");
        strobe(8'h3D, 1, "R5 change restarts");
        for (int l = 0; l < NL; l++) strobe(8'h3D, 2, "R5 fresh run stops");

        // R2: a single flipped bit at any position counts as a change
        for (int b = 0; b < NB; b++) begin
            do_start();
            for (int l = 0; l < NL - 1; l++) strobe(8'h00, 1, "R2 quiet prefix");
            strobe(NB'(1) << b, 1, "R2 single bit change");
            for (int l = 0; l < NL; l++) strobe(NB'(1) << b, 2, "R2 settle");
        end

        // R3 / R6: sweep the iteration at which decisions settle
        for (int conv = 1; conv <= MI; conv++) begin
            do_start();
            for (int it = 0; it < MI; it++) begin
                for (int l = 0; l < NL; l++) begin
                    if (!m_stop)
                        strobe((it < conv) ? NB'(it * NL + l + 1) : 8'hA5, it,
                               (conv >= MI - 1) ? "R6 cap stop" : "R3 sweep");
                end
            end
            chk("R6 stopped by end", int'(stop_o), 1);
        end

        // R9: start in the same cycle as a strobe wins, stored bits cleared
        @(negedge clk); start_i = 1'b1; layer_done_i = 1'b1; post_sign_i = 8'hFF; iter_idx_i = 4'd1;
        @(negedge clk); start_i = 1'b0; layer_done_i = 1'b0;
        m_run = 1; m_stop = 0; m_hist = '0; m_quiet = 0; m_pos = 0;
        chk("R9 start priority", int'(stop_o), 0);
        for (int l = 0; l < NL; l++) strobe(8'h00, 1, "R9 history cleared");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule